// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the address that a microprogrammed control unit presents to its control store each cycle. It holds the current control-store address and a single saved return address. From the microinstruction word that the store returns, it takes a two-bit condition selector, a two-bit branch kind and a seven-bit target field. From the machine instruction it takes a four-bit opcode, and from the datapath it takes three status flags. From these it picks the next address from one of four sources: the incremented address, the target field, an opcode dispatch address, or the saved return address.

The condition selector chooses which status flag is tested. The branch kind then decides what the test means:
- a jump or a call is taken only when the test is true;
- a return or a dispatch ignores the test.

A taken call also records the address that follows the call, and the block raises a strobe while that save is being made. The microoperation fields of the word pass the block by without effect. The control store itself and the datapath registers sit outside the block.

Top module: `mseq_next_address`

## Requirements
- R1: A synchronous active-high reset sets the address output to 64 and clears the saved return address to 0, so a return issued right after reset goes to 0.
- R2: The condition selector (word bits 10:9) picks the tested flag: 0 is always true, 1 is the indirect flag, 2 is the accumulator sign flag, 3 is the accumulator-zero flag.
- R3: Branch kind 0 (word bits 8:7, jump) loads the target field (word bits 6:0) when the test is true, and loads the current address plus one otherwise.
- R4: Branch kind 1 (call) with a true test loads the target field and saves the current address plus one as the return address.
- R5: Branch kind 1 with a false test loads the current address plus one and leaves the saved return address unchanged.
- R6: Branch kind 2 (return) loads the saved return address whatever the test result.
- R7: Branch kind 3 (dispatch) loads {0, opcode[3:0], 00}, so opcode 1 gives 4 and opcode 3 gives 12, whatever the test result.
- R8: The save strobe is high in the same cycle that a call with a true test is presented, and low in every other case.
- R9: Only one return address is kept, so a second call made before a return replaces the first saved address.
- R10: The incremented address wraps from 127 to 0.
- R11: The three microoperation fields (word bits 19:11) have no effect on the next address or on the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uword | input | 20 | Microinstruction word read from the control store |
| opcode | input | 4 | Machine opcode used for dispatch |
| ind_flag | input | 1 | Indirect-addressing flag |
| acc_sign | input | 1 | Accumulator sign flag |
| acc_zero | input | 1 | Accumulator-is-zero flag |
| ctl_addr | output | 7 | Current control-store address |
| ret_save | output | 1 | High while a taken call writes the return address |

## Verification
The saved return address has no port of its own, so the hardest behaviour to observe is whether a call that is not taken leaves it untouched, or whether a later call replaces it. The stimulus reaches this state by following each call, taken or not, with a later return, and reading the saved value from the address output. A nested pair of calls followed by two returns shows that only the newer return address survives. The full sweep of branch kind, condition selector and all eight flag patterns runs from many start addresses, including 127, so that the wrap of the incremented address is exercised along the way.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

   localparam int unsigned UOP_W  = 3;
   localparam int unsigned UOP_N  = 3;
   localparam int unsigned COND_W = 2;
   localparam int unsigned KIND_W = 2;

   typedef enum logic [KIND_W-1:0] {
      BK_JUMP     = 2'b00,
      BK_CALL     = 2'b01,
      BK_RETURN   = 2'b10,
      BK_DISPATCH = 2'b11
   } branch_kind_e;

   // the select code for return and dispatch equals the branch kind
   typedef enum logic [1:0] {
      SRC_INC      = 2'b00,
      SRC_TARGET   = 2'b01,
      SRC_RETURN   = 2'b10,
      SRC_DISPATCH = 2'b11
   } addr_src_e;

   typedef enum logic [COND_W-1:0] {
      CC_ALWAYS   = 2'b00,
      CC_INDIRECT = 2'b01,
      CC_SIGN     = 2'b10,
      CC_ZERO     = 2'b11
   } cond_code_e;

endpackage

// File: rtl/mseq_cond_pick.sv
module mseq_cond_pick
   import mseq_pkg::*;
#(
   parameter int unsigned SEL_W = COND_W
) (
   input  logic [SEL_W-1:0] cond_sel,
   input  logic             ind_flag,
   input  logic             acc_sign,
   input  logic             acc_zero,
   output logic             test
);

   localparam int unsigned NUM_SRC = 1 << SEL_W;

   if (NUM_SRC != 4) begin : g_bad_sel
      $error("mseq_cond_pick: selector must address exactly four conditions");
   end

   logic [NUM_SRC-1:0] flags;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
      if (i == int'(CC_ALWAYS)) begin : g_one
         assign flags[i] = 1'b1;
      end else if (i == int'(CC_INDIRECT)) begin : g_ind
         assign flags[i] = ind_flag;
      end else if (i == int'(CC_SIGN)) begin : g_sgn
         assign flags[i] = acc_sign;
      end else begin : g_zro
         assign flags[i] = acc_zero;
      end
   end

   assign test = flags[cond_sel];

endmodule

// File: rtl/mseq_src_ctrl.sv
module mseq_src_ctrl
   import mseq_pkg::*;
(
   input  branch_kind_e kind,
   input  logic         test,
   output addr_src_e    src_sel,
   output logic         ret_load
);

   always_comb begin
      if (kind[1]) begin
         src_sel = addr_src_e'(kind);
      end else begin
         src_sel = addr_src_e'({1'b0, test});
      end
   end

   assign ret_load = (kind == BK_CALL) && test;

   always_comb begin
      if (ret_load) begin
         AST_LOAD_TARGET: assert (src_sel == SRC_TARGET);  // R8
      end
   end

endmodule

// File: rtl/mseq_opc_map.sv
module mseq_opc_map #(
   parameter int unsigned OPC_W     = 4,
   parameter int unsigned ADDR_W    = 7,
   parameter int unsigned LOW_ZEROS = 2
) (
   input  logic [OPC_W-1:0]  opcode,
   output logic [ADDR_W-1:0] disp_addr
);

   localparam int unsigned USED_W = OPC_W + LOW_ZEROS;

   if (USED_W > ADDR_W) begin : g_bad_w
      $error("mseq_opc_map: opcode plus slot bits exceed the address width");
   end

   if (USED_W == ADDR_W) begin : g_exact
      assign disp_addr = {opcode, {LOW_ZEROS{1'b0}}};
   end else begin : g_pad
      assign disp_addr = {{(ADDR_W-USED_W){1'b0}}, opcode, {LOW_ZEROS{1'b0}}};
   end

endmodule

// File: rtl/mseq_next_address.sv
module mseq_next_address
   import mseq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 7,
   parameter int unsigned OPC_W      = 4,
   parameter int unsigned SLOT_BITS  = 2,
   parameter int unsigned RESET_ADDR = 64,
   parameter int unsigned WORD_W     = UOP_N*UOP_W + COND_W + KIND_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] uword,
   input  logic [OPC_W-1:0]  opcode,
   input  logic              ind_flag,
   input  logic              acc_sign,
   input  logic              acc_zero,
   output logic [ADDR_W-1:0] ctl_addr,
   output logic              ret_save
);

   localparam int unsigned TGT_LSB  = 0;
   localparam int unsigned KIND_LSB = TGT_LSB + ADDR_W;
   localparam int unsigned COND_LSB = KIND_LSB + KIND_W;
   localparam int unsigned UOP_LSB  = COND_LSB + COND_W;
   localparam int unsigned NEED_W   = UOP_LSB + UOP_N*UOP_W;

   if (WORD_W != NEED_W) begin : g_bad_word
      $error("mseq_next_address: word width does not match the field layout");
   end
   if (RESET_ADDR >= (1 << ADDR_W)) begin : g_bad_reset
      $error("mseq_next_address: reset address out of range");
   end

   logic [ADDR_W-1:0] target;
   branch_kind_e      kind;
   logic [COND_W-1:0] cond_sel;
   logic              unused_uops;

   assign target      = uword[TGT_LSB +: ADDR_W];
   assign kind        = branch_kind_e'(uword[KIND_LSB +: KIND_W]);
   assign cond_sel    = uword[COND_LSB +: COND_W];
   assign unused_uops = ^uword[UOP_LSB +: UOP_N*UOP_W];

   logic              test;
   addr_src_e         src_sel;
   logic [ADDR_W-1:0] disp_addr;
   logic [ADDR_W-1:0] inc_addr;
   logic [ADDR_W-1:0] next_addr;
   logic [ADDR_W-1:0] ret_q;

   mseq_cond_pick #(.SEL_W(COND_W)) i_cond (
      .cond_sel (cond_sel),
      .ind_flag (ind_flag),
      .acc_sign (acc_sign),
      .acc_zero (acc_zero),
      .test     (test)
   );

   mseq_src_ctrl i_ctrl (
      .kind     (kind),
      .test     (test),
      .src_sel  (src_sel),
      .ret_load (ret_save)
   );

   mseq_opc_map #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .LOW_ZEROS(SLOT_BITS)) i_map (
      .opcode    (opcode),
      .disp_addr (disp_addr)
   );

   // modulo 2**ADDR_W by truncation
   assign inc_addr = ctl_addr + 1'b1;

   always_comb begin
      unique case (src_sel)
         SRC_INC:      next_addr = inc_addr;
         SRC_TARGET:   next_addr = target;
         SRC_RETURN:   next_addr = ret_q;
         SRC_DISPATCH: next_addr = disp_addr;
         default:      next_addr = inc_addr;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_addr <= ADDR_W'(RESET_ADDR);
         ret_q    <= '0;
      end else begin
         ctl_addr <= next_addr;
         if (ret_save) begin
            ret_q <= inc_addr;
         end
      end
   end

   AST_RESET_START: assert property (@(posedge clk)
      $past(rst) |-> (ctl_addr == ADDR_W'(RESET_ADDR)));  // R1

   AST_JUMP_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
      (kind == BK_JUMP && !test) |=> (ctl_addr == ADDR_W'($past(ctl_addr) + 1'b1)));  // R3

   AST_CALL_SAVES: assert property (@(posedge clk) disable iff (rst)
      ret_save |=> (ret_q == ADDR_W'($past(ctl_addr) + 1'b1)) && (ctl_addr == $past(target)));  // R4

   AST_RET_HOLD: assert property (@(posedge clk) disable iff (rst)
      !ret_save |=> $stable(ret_q));  // R5

   AST_RETURN_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (kind == BK_RETURN) |=> (ctl_addr == $past(ret_q)));  // R6

   AST_DISPATCH_SHAPE: assert property (@(posedge clk) disable iff (rst)
      (kind == BK_DISPATCH) |=> (ctl_addr[SLOT_BITS-1:0] == '0));  // R7

   AST_STROBE_ONLY_CALL: assert property (@(posedge clk) disable iff (rst)
      ret_save |-> (kind == BK_CALL));  // R8

endmodule

// File: tb/test_mseq_next_address.sv
module test_mseq_next_address;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [19:0] uword = '0;
   logic [3:0]  opcode = '0;
   logic        ind_flag = 1'b0;
   logic        acc_sign = 1'b0;
   logic        acc_zero = 1'b0;
   logic [6:0]  ctl_addr;
   logic        ret_save;

   int checks = 0;
   int fails  = 0;
   int exp_addr;
   int exp_ret;
   bit done = 1'b0;

   always #2 clk = ~clk;

   mseq_next_address i_mseq_next_address (
      .clk(clk), .rst(rst), .uword(uword), .opcode(opcode),
      .ind_flag(ind_flag), .acc_sign(acc_sign), .acc_zero(acc_zero),
      .ctl_addr(ctl_addr), .ret_save(ret_save)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // one microinstruction: drive, check strobe, clock, check address
   task automatic step(input int kind, input int cc, input int tgt, input int st,
                       input int opc, input int uops, input string req);
      bit t;
      int nxt;
      int inc;
      uword    = 20'((uops << 11) | (cc << 9) | (kind << 7) | tgt);
      opcode   = 4'(opc);
      ind_flag = st[0];
      acc_sign = st[1];
      acc_zero = st[2];
      #1;
      case (cc)
         0: t = 1'b1;
         1: t = st[0];
         2: t = st[1];
         default: t = st[2];
      endcase
      inc = (exp_addr + 1) % 128;
      chk("R8", int'(ret_save), int'(kind == 1 && t));
      case (kind)
         0: nxt = t ? tgt : inc;
         1: begin
            nxt = t ? tgt : inc;
            if (t) exp_ret = inc;
         end
         2: nxt = exp_ret;
         default: nxt = opc * 4;
      endcase
      tick();
      exp_addr = nxt;
      chk(req, int'(ctl_addr), exp_addr);
   endtask

   initial begin
      repeat (3) tick();
      chk("R1 reset address", int'(ctl_addr), 64);
      rst = 1'b0;
      exp_addr = 64;
      exp_ret  = 0;
      step(2, 3, 99, 0, 0, 0, "R1 return after reset");

      // full sweep: kind x condition x flags, varied start and uop bits (R2 R11)
      for (int k = 0; k < 4; k++) begin
         for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 8; s++) begin
               int start;
               string tag;
               start = (k*37 + c*11 + s*17 + 5) % 128;
               step(0, 0, start, 0, 0, (s*73) % 512, "R2 R3 setup jump");
               case (k)
                  0: tag = "R2 R3 R11 jump";
                  1: tag = "R2 R4 R5 call";
                  2: tag = "R6 return";
                  default: tag = "R7 dispatch";
               endcase
               step(k, c, (start*5 + 17) % 128, s, (k + c + s) % 16, 511 - s*9, tag);
               step(2, c, 0, 7 - s, 0, s, "R4 R5 R6 saved address");
            end
         end
      end

      // every opcode through dispatch
      for (int o = 0; o < 16; o++) begin
         step(3, o % 4, 127 - o, o % 8, o, o * 31, "R7 opcode map");
      end

      // wrap of the increment
      step(0, 0, 127, 0, 0, 0, "R3 to 127");
      step(0, 1, 50, 0, 0, 0, "R10 wrap false jump");
      step(0, 0, 127, 0, 0, 0, "R3 to 127");
      step(1, 2, 9, 0, 0, 0, "R5 R10 wrap false call");
      step(0, 0, 127, 0, 0, 0, "R3 to 127");
      step(1, 0, 9, 0, 0, 0, "R4 R10 call from 127");
      step(2, 0, 0, 0, 0, 0, "R6 R10 return to 0");

      // nested calls keep only the newest return
      step(0, 0, 20, 0, 0, 0, "R3 to 20");
      step(1, 3, 10, 4, 0, 0, "R4 outer call");
      step(1, 0, 30, 0, 0, 0, "R9 inner call");
      step(2, 1, 0, 1, 0, 0, "R9 first return");
      chk("R9 first return lands", int'(ctl_addr), 11);
      step(2, 2, 0, 0, 0, 0, "R9 second return");
      chk("R9 outer address lost", int'(ctl_addr), 11);

      // uop fields alone changed: same result
      step(0, 2, 40, 2, 0, 0, "R11 uops zero");
      step(0, 0, 60, 0, 0, 0, "R3 to 60");
      step(0, 2, 40, 2, 0, 511, "R11 uops all ones");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule